// File: doc/BRIEF.md
# DDR4 Mode Register Init Sequencer

This block runs the power-up mode-register programming of a DDR4 device. On a start request it encodes four timing values into their register codes: CAS latency, write recovery (which also sets read-to-precharge), CAS write latency and the long column-to-column delay. It then builds seven mode-register words from these codes and hands them one at a time to a command port. The port performs the actual bus write, so the timing of the DRAM command bus stays outside this block.

Each word is offered with a valid/ready handshake. After a word is accepted, the block waits for the command port to raise its completion signal and then to drop it again. Only after that does it offer the next word. The completion signal is never treated as a one-cycle pulse.

Two start requests do not run the sequence. A start request for a non-DDR4 memory type finishes at once without any command. A start request with an unsupported timing value raises an error flag and issues nothing.

Top module: `ddr4_mr_init_seq`

## Requirements
- R1: Once a valid DDR4 start is accepted, exactly seven words are issued, to mode registers 3, 6, 5, 4, 2, 1 and 0 in that order. After a word is accepted, no further word is offered until `cmd_done_i` has been seen high and then low again.
- R2: Back-pressure: while `cmd_valid_o` is high and `cmd_ready_i` is low, `cmd_valid_o`, `cmd_addr_o` and `cmd_op_o` hold their values. A word counts as accepted on the clock edge where valid and ready are both high.
- R3: CAS latency code (5 bits) is mapped as follows:
  - CL 9..16 give codes 0..7.
  - CL 18, 20, 22, 24 give codes 8..11.
  - CL 23, 17, 19, 21 give codes 12..15.
  - CL 25..28 give codes 16..19.
  - CL 30 gives code 21 and CL 32 gives code 23.
  - In the MR0 word, code bit 0 sits at bit 2, code bits 3:1 at bits 6:4, and code bit 4 at bit 12.
- R4: Write-recovery code (4 bits) is mapped as follows:
  - WR 5..10 give codes 0..5.
  - WR 12 gives 6, WR 11 gives 7 and WR 13 gives 8.
  - In the MR0 word, code bits 2:0 sit at bits 11:9 and code bit 3 at bit 13.
  - All MR0 bits not named in R3 or R4 are zero.
- R5: The MR2 word is 0x200 plus the CAS write latency code at bits 5:3. CWL 9, 10, 11, 12, 14, 16, 18, 20 give codes 0..7.
- R6: The MR6 word carries the tCCD_L code at bits 12:10, with tCCD_L 4..8 giving codes 0..4. All other bits are zero.
- R7: The MR1 word is 0x201, the MR5 word is 0x420, and the MR3 and MR4 words are zero.
- R8: A start with `is_ddr4_i` low raises `done_o` on the next cycle, clears `err_o`, keeps `busy_o` low and issues no command.
- R9: A DDR4 start with any timing value outside the tables of R3 to R6 raises `err_o` on the next cycle, issues no command and keeps `busy_o` low. An accepted start clears both `err_o` and `done_o`.
- R10: A start request while `busy_o` is high is ignored. The timing values are captured at the accepted start, so input changes during a run have no effect on the words issued.
- R11: After reset, `busy_o`, `done_o`, `err_o` and `cmd_valid_o` are low.
- R12: `busy_o` is high from the cycle after an accepted DDR4 start until the final release of `cmd_done_i`. In the cycle after that release, `busy_o` falls and `done_o` rises and stays high until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| is_ddr4_i | input | 1 | High selects DDR4; low skips the sequence |
| cl_i | input | CL_W | CAS latency in clocks |
| wr_i | input | TW_W | Write recovery / read-to-precharge in clocks |
| cwl_i | input | TW_W | CAS write latency in clocks |
| tccdl_i | input | CCD_W | Same-group column-to-column delay in clocks |
| cmd_valid_o | output | 1 | Mode-register word offered |
| cmd_ready_i | input | 1 | Command port accepts the offered word |
| cmd_addr_o | output | MR_ADDR_W | Mode register number |
| cmd_op_o | output | OP_W | Mode register opcode |
| cmd_done_i | input | 1 | Command port completion level |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished or skipped |
| err_o | output | 1 | Last start carried an unsupported value |

## Verification
Two directed runs use chosen latencies whose MR0, MR2 and MR6 words are compared against literal hand-derived values. These runs separate a wrong bit scatter from a wrong code table. Randomized runs draw every legal value from each table, so the irregular entries of the CAS and write-recovery tables are hit as well as the regular ones. The command responder varies both ready and completion delays to expose any word that moves under back-pressure or issues before the release.

Further runs cover the other ways a start can end. Starts with out-of-table values and with the non-DDR4 type show whether the error and skip paths issue commands. A start pulse with different, partly illegal values in the middle of a run shows whether a busy block re-captures its inputs.

// File: rtl/ddr4_mr_pkg.sv
package ddr4_mr_pkg;

  localparam int SEQ_LEN  = 7;
  localparam int MR_VAL_W = 14;

  typedef struct packed {
    logic [4:0] cas;
    logic [3:0] wrec;
    logic [2:0] cwl;
    logic [2:0] ccd;
  } mr_codes_t;

  // Mode register targeted at each step of the power-up order.
  function automatic logic [2:0] step_to_mr(input int unsigned step);
    case (step)
      0:       step_to_mr = 3'd3;
      1:       step_to_mr = 3'd6;
      2:       step_to_mr = 3'd5;
      3:       step_to_mr = 3'd4;
      4:       step_to_mr = 3'd2;
      5:       step_to_mr = 3'd1;
      default: step_to_mr = 3'd0;
    endcase
  endfunction

  // Word written to mode register 'mr' for the captured codes.
  function automatic logic [MR_VAL_W-1:0] mr_word(input logic [2:0] mr, input mr_codes_t c);
    logic [MR_VAL_W-1:0] v;
    v = '0;
    case (mr)
      3'd0: begin
        v[2]    = c.cas[0];
        v[6:4]  = c.cas[3:1];
        v[12]   = c.cas[4];
        v[11:9] = c.wrec[2:0];
        v[13]   = c.wrec[3];
      end
      3'd1: v = 14'h0201;
      3'd2: begin
        v      = 14'h0200;
        v[5:3] = c.cwl;
      end
      3'd5: v = 14'h0420;
      3'd6: v[12:10] = c.ccd;
      default: v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/ddr4_mr_code_enc.sv
module ddr4_mr_code_enc
  import ddr4_mr_pkg::*;
#(
  parameter int CL_W  = 6,
  parameter int TW_W  = 5,
  parameter int CCD_W = 4
) (
  input  logic [CL_W-1:0]  cl_i,
  input  logic [TW_W-1:0]  wr_i,
  input  logic [TW_W-1:0]  cwl_i,
  input  logic [CCD_W-1:0] tccdl_i,
  output mr_codes_t        codes_o,
  output logic             ok_o
);

  logic cas_ok, wr_ok, cwl_ok, ccd_ok;

  always_comb begin
    cas_ok = 1'b1;
    case (32'(cl_i))
      9:  codes_o.cas = 5'h00;
      10: codes_o.cas = 5'h01;
      11: codes_o.cas = 5'h02;
      12: codes_o.cas = 5'h03;
      13: codes_o.cas = 5'h04;
      14: codes_o.cas = 5'h05;
      15: codes_o.cas = 5'h06;
      16: codes_o.cas = 5'h07;
      18: codes_o.cas = 5'h08;
      20: codes_o.cas = 5'h09;
      22: codes_o.cas = 5'h0A;
      24: codes_o.cas = 5'h0B;
      23: codes_o.cas = 5'h0C;
      17: codes_o.cas = 5'h0D;
      19: codes_o.cas = 5'h0E;
      21: codes_o.cas = 5'h0F;
      25: codes_o.cas = 5'h10;
      26: codes_o.cas = 5'h11;
      27: codes_o.cas = 5'h12;
      28: codes_o.cas = 5'h13;
      30: codes_o.cas = 5'h15;
      32: codes_o.cas = 5'h17;
      default: begin codes_o.cas = 5'h00; cas_ok = 1'b0; end
    endcase

    wr_ok = 1'b1;
    case (32'(wr_i))
      5:  codes_o.wrec = 4'd0;
      6:  codes_o.wrec = 4'd1;
      7:  codes_o.wrec = 4'd2;
      8:  codes_o.wrec = 4'd3;
      9:  codes_o.wrec = 4'd4;
      10: codes_o.wrec = 4'd5;
      12: codes_o.wrec = 4'd6;
      11: codes_o.wrec = 4'd7;
      13: codes_o.wrec = 4'd8;
      default: begin codes_o.wrec = 4'd0; wr_ok = 1'b0; end
    endcase

    cwl_ok = 1'b1;
    case (32'(cwl_i))
      9:  codes_o.cwl = 3'd0;
      10: codes_o.cwl = 3'd1;
      11: codes_o.cwl = 3'd2;
      12: codes_o.cwl = 3'd3;
      14: codes_o.cwl = 3'd4;
      16: codes_o.cwl = 3'd5;
      18: codes_o.cwl = 3'd6;
      20: codes_o.cwl = 3'd7;
      default: begin codes_o.cwl = 3'd0; cwl_ok = 1'b0; end
    endcase

    ccd_ok = 1'b1;
    case (32'(tccdl_i))
      4: codes_o.ccd = 3'd0;
      5: codes_o.ccd = 3'd1;
      6: codes_o.ccd = 3'd2;
      7: codes_o.ccd = 3'd3;
      8: codes_o.ccd = 3'd4;
      default: begin codes_o.ccd = 3'd0; ccd_ok = 1'b0; end
    endcase
  end

  assign ok_o = cas_ok & wr_ok & cwl_ok & ccd_ok;

endmodule

// File: rtl/ddr4_mr_word_build.sv
module ddr4_mr_word_build
  import ddr4_mr_pkg::*;
#(
  parameter int MR_ADDR_W = 3,
  parameter int OP_W      = 14,
  localparam int IDX_W    = $clog2(SEQ_LEN)
) (
  input  mr_codes_t            codes_i,
  input  logic [IDX_W-1:0]     step_i,
  output logic [MR_ADDR_W-1:0] addr_o,
  output logic [OP_W-1:0]      op_o
);

  logic [MR_VAL_W-1:0] words [SEQ_LEN];
  logic [2:0]          mrs   [SEQ_LEN];

  for (genvar g = 0; g < SEQ_LEN; g++) begin : g_step
    assign mrs[g]   = step_to_mr(g);
    assign words[g] = mr_word(mrs[g], codes_i);
  end

  assign addr_o = MR_ADDR_W'(mrs[step_i]);
  assign op_o   = OP_W'(words[step_i]);

endmodule

// File: rtl/ddr4_mr_seq_fsm.sv
module ddr4_mr_seq_fsm
  import ddr4_mr_pkg::*;
#(
  localparam int IDX_W = $clog2(SEQ_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             is_ddr4_i,
  input  logic             codes_ok_i,
  input  logic             cmd_ready_i,
  input  logic             cmd_done_i,
  output logic             capture_o,
  output logic [IDX_W-1:0] step_o,
  output logic             cmd_valid_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT_HI, S_WAIT_LO} st_t;

  localparam logic [IDX_W-1:0] LAST = IDX_W'(SEQ_LEN - 1);

  st_t              state;
  logic [IDX_W-1:0] step;
  logic             done_q, err_q;

  assign capture_o = (state == S_IDLE) && start_i && is_ddr4_i && codes_ok_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      step   <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start_i) begin
          if (!is_ddr4_i) begin
            done_q <= 1'b1;
            err_q  <= 1'b0;
          end else if (!codes_ok_i) begin
            done_q <= 1'b0;
            err_q  <= 1'b1;
          end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            step   <= '0;
            state  <= S_ISSUE;
          end
        end
        S_ISSUE:   if (cmd_ready_i) state <= S_WAIT_HI;
        S_WAIT_HI: if (cmd_done_i)  state <= S_WAIT_LO;
        S_WAIT_LO: if (!cmd_done_i) begin
          if (step == LAST) begin
            state  <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            step  <= step + 1'b1;
            state <= S_ISSUE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign step_o      = step;
  assign cmd_valid_o = (state == S_ISSUE);
  assign busy_o      = (state != S_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;

endmodule

// File: rtl/ddr4_mr_init_seq.sv
module ddr4_mr_init_seq
  import ddr4_mr_pkg::*;
#(
  parameter int CL_W      = 6,
  parameter int TW_W      = 5,
  parameter int CCD_W     = 4,
  parameter int MR_ADDR_W = 3,
  parameter int OP_W      = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 is_ddr4_i,
  input  logic [CL_W-1:0]      cl_i,
  input  logic [TW_W-1:0]      wr_i,
  input  logic [TW_W-1:0]      cwl_i,
  input  logic [CCD_W-1:0]     tccdl_i,
  output logic                 cmd_valid_o,
  input  logic                 cmd_ready_i,
  output logic [MR_ADDR_W-1:0] cmd_addr_o,
  output logic [OP_W-1:0]      cmd_op_o,
  input  logic                 cmd_done_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 err_o
);

  localparam int IDX_W = $clog2(SEQ_LEN);

  mr_codes_t        codes_d, codes_q;
  logic             codes_ok, capture;
  logic [IDX_W-1:0] step;

  ddr4_mr_code_enc #(.CL_W(CL_W), .TW_W(TW_W), .CCD_W(CCD_W)) u_enc (
    .cl_i    (cl_i),
    .wr_i    (wr_i),
    .cwl_i   (cwl_i),
    .tccdl_i (tccdl_i),
    .codes_o (codes_d),
    .ok_o    (codes_ok)
  );

  // Codes are frozen at the accepted start (R10).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       codes_q <= '0;
    else if (capture) codes_q <= codes_d;
  end

  ddr4_mr_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .is_ddr4_i   (is_ddr4_i),
    .codes_ok_i  (codes_ok),
    .cmd_ready_i (cmd_ready_i),
    .cmd_done_i  (cmd_done_i),
    .capture_o   (capture),
    .step_o      (step),
    .cmd_valid_o (cmd_valid_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o)
  );

  ddr4_mr_word_build #(.MR_ADDR_W(MR_ADDR_W), .OP_W(OP_W)) u_build (
    .codes_i (codes_q),
    .step_i  (step),
    .addr_o  (cmd_addr_o),
    .op_o    (cmd_op_o)
  );

endmodule

// File: rtl/ddr4_mr_init_seq_chk.sv
module ddr4_mr_init_seq_chk #(
  parameter int MR_ADDR_W = 3,
  parameter int OP_W      = 14
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start_i,
  input logic                 is_ddr4_i,
  input logic                 cmd_valid_o,
  input logic                 cmd_ready_i,
  input logic [MR_ADDR_W-1:0] cmd_addr_o,
  input logic [OP_W-1:0]      cmd_op_o,
  input logic                 cmd_done_i,
  input logic                 busy_o,
  input logic                 done_o,
  input logic                 err_o
);

  assert_first_mr3_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> cmd_valid_o && cmd_addr_o == MR_ADDR_W'(3));

  assert_no_issue_in_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done_i |-> !cmd_valid_o);

  assert_hold_under_backpressure_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_addr_o) && $stable(cmd_op_o));

  assert_mr1_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && cmd_addr_o == MR_ADDR_W'(1) |-> cmd_op_o == OP_W'(14'h0201));

  assert_mr5_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && cmd_addr_o == MR_ADDR_W'(5) |-> cmd_op_o == OP_W'(14'h0420));

  assert_skip_non_ddr4_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o && !is_ddr4_i |=> done_o && !busy_o && !err_o);

  assert_err_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !busy_o && !done_o && !cmd_valid_o);

  assert_valid_in_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> busy_o);

  assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

endmodule

bind ddr4_mr_init_seq ddr4_mr_init_seq_chk #(.MR_ADDR_W(MR_ADDR_W), .OP_W(OP_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .is_ddr4_i   (is_ddr4_i),
  .cmd_valid_o (cmd_valid_o),
  .cmd_ready_i (cmd_ready_i),
  .cmd_addr_o  (cmd_addr_o),
  .cmd_op_o    (cmd_op_o),
  .cmd_done_i  (cmd_done_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o)
);

// File: tb/ddr4_mr_init_seq_bench.sv
module ddr4_mr_init_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        is_ddr4_i = 1'b1;
  logic [5:0]  cl_i = '0;
  logic [4:0]  wr_i = '0;
  logic [4:0]  cwl_i = '0;
  logic [3:0]  tccdl_i = '0;
  logic        cmd_ready_i = 1'b0;
  logic        cmd_done_i = 1'b0;
  logic        cmd_valid_o, busy_o, done_o, err_o;
  logic [2:0]  cmd_addr_o;
  logic [13:0] cmd_op_o;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;
  int last_ops [7];

  int cl_list  [22] = '{9,10,11,12,13,14,15,16,17,18,19,20,21,22,23,24,25,26,27,28,30,32};
  int wr_list  [9]  = '{5,6,7,8,9,10,11,12,13};
  int cwl_list [8]  = '{9,10,11,12,14,16,18,20};
  int order    [7]  = '{3,6,5,4,2,1,0};

  always #10 clk = ~clk;  // 50 MHz

  ddr4_mr_init_seq u_ddr4_mr_init_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .is_ddr4_i(is_ddr4_i),
    .cl_i(cl_i), .wr_i(wr_i), .cwl_i(cwl_i), .tccdl_i(tccdl_i),
    .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i),
    .cmd_addr_o(cmd_addr_o), .cmd_op_o(cmd_op_o), .cmd_done_i(cmd_done_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  function automatic int cas_code(int cl);
    if (cl >= 9 && cl <= 16)  return cl - 9;
    if (cl == 18 || cl == 20 || cl == 22 || cl == 24) return 8 + (cl - 18) / 2;
    if (cl == 23) return 12;
    if (cl == 17 || cl == 19 || cl == 21) return 13 + (cl - 17) / 2;
    if (cl >= 25 && cl <= 28) return 16 + cl - 25;
    if (cl == 30) return 21;
    return 23;
  endfunction

  function automatic int wr_code(int w);
    if (w <= 10) return w - 5;
    if (w == 11) return 7;
    if (w == 12) return 6;
    return 8;
  endfunction

  function automatic int cwl_code(int c);
    if (c <= 12) return c - 9;
    return 4 + (c - 14) / 2;
  endfunction

  function automatic int exp_word(int mr, int cl, int w, int cwl, int ccd);
    int cc, wc;
    cc = cas_code(cl);
    wc = wr_code(w);
    case (mr)
      0: return ((cc % 2) * 4) + (((cc / 2) % 8) * 16) + ((cc / 16) * 4096)
              + ((wc % 8) * 512) + ((wc / 8) * 8192);
      1: return 'h201;
      2: return 'h200 + cwl_code(cwl) * 8;
      5: return 'h420;
      6: return (ccd - 4) * 1024;
      default: return 0;
    endcase
  endfunction

  function automatic string word_req(int mr);
    case (mr)
      0: return "R3/R4";
      2: return "R5";
      6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  // Full DDR4 run; 'poke' fires a start with other values mid-run (R10).
  task automatic run_seq(input int cl, input int w, input int cwl, input int ccd, input bit poke);
    @(negedge clk);
    is_ddr4_i = 1'b1;
    cl_i = 6'(cl); wr_i = 5'(w); cwl_i = 5'(cwl); tccdl_i = 4'(ccd);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R12 busy after start", int'(busy_o), 1);
    chk(done_o == 1'b0 && err_o == 1'b0, "R9 flags cleared by start", int'({done_o, err_o}), 0);
    for (int k = 0; k < 7; k++) begin
      int d, e, h;
      logic [2:0]  a0;
      logic [13:0] o0;
      chk(cmd_valid_o == 1'b1 && int'(cmd_addr_o) == order[k], "R1 order",
          int'(cmd_addr_o), order[k]);
      a0 = cmd_addr_o;
      o0 = cmd_op_o;
      d = $urandom_range(0, 3);
      if (poke && k == 2 && d == 0) d = 1;
      for (int i = 0; i < d; i++) begin
        if (poke && k == 2 && i == 0) begin
          start_i = 1'b1; cl_i = 6'd31; wr_i = 5'd11; cwl_i = 5'd9; tccdl_i = 4'd7;
        end
        @(negedge clk);
        start_i = 1'b0;
        chk(cmd_valid_o && cmd_addr_o == a0 && cmd_op_o == o0, "R2 hold",
            int'(cmd_op_o), int'(o0));
      end
      cmd_ready_i = 1'b1;
      chk(int'(cmd_op_o) == exp_word(order[k], cl, w, cwl, ccd), word_req(order[k]),
          int'(cmd_op_o), exp_word(order[k], cl, w, cwl, ccd));
      last_ops[k] = int'(cmd_op_o);
      @(negedge clk);
      cmd_ready_i = 1'b0;
      chk(cmd_valid_o == 1'b0, "R1 no offer before done", int'(cmd_valid_o), 0);
      e = $urandom_range(0, 3);
      for (int i = 0; i < e; i++) begin
        @(negedge clk);
        chk(cmd_valid_o == 1'b0, "R1 wait for done", int'(cmd_valid_o), 0);
      end
      cmd_done_i = 1'b1;
      h = $urandom_range(1, 3);
      for (int i = 0; i < h; i++) begin
        @(negedge clk);
        chk(cmd_valid_o == 1'b0, "R1 wait for release", int'(cmd_valid_o), 0);
      end
      cmd_done_i = 1'b0;
      @(negedge clk);
    end
    chk(done_o == 1'b1 && busy_o == 1'b0 && cmd_valid_o == 1'b0, "R12 completion",
        int'({done_o, busy_o, cmd_valid_o}), 4);
    if (poke) chk(err_o == 1'b0, "R10 busy start ignored", int'(err_o), 0);
  endtask

  task automatic run_bad(input int cl, input int w, input int cwl, input int ccd, input string req);
    @(negedge clk);
    is_ddr4_i = 1'b1;
    cl_i = 6'(cl); wr_i = 5'(w); cwl_i = 5'(cwl); tccdl_i = 4'(ccd);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(err_o == 1'b1 && done_o == 1'b0 && busy_o == 1'b0, req,
        int'({err_o, done_o, busy_o}), 4);
    repeat (3) begin
      @(negedge clk);
      chk(cmd_valid_o == 1'b0, "R9 no command on error", int'(cmd_valid_o), 0);
    end
  endtask

  task automatic run_skip();
    @(negedge clk);
    is_ddr4_i = 1'b0;
    cl_i = 6'd20; wr_i = 5'd12; cwl_i = 5'd16; tccdl_i = 4'd8;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    is_ddr4_i = 1'b1;
    chk(done_o == 1'b1 && busy_o == 1'b0 && err_o == 1'b0, "R8 skip",
        int'({done_o, busy_o, err_o}), 4);
    repeat (4) begin
      @(negedge clk);
      chk(cmd_valid_o == 1'b0 && busy_o == 1'b0, "R8 no command", int'(cmd_valid_o), 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1d4c_0a57));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o && !err_o && !cmd_valid_o, "R11 reset state",
        int'({busy_o, done_o, err_o, cmd_valid_o}), 0);

    run_seq(20, 12, 16, 8, 1'b0);
    chk(last_ops[6] == 'h0C44, "R3 MR0 literal CL20/WR12", last_ops[6], 'h0C44);
    chk(last_ops[1] == 'h1000, "R6 MR6 literal", last_ops[1], 'h1000);
    chk(last_ops[4] == 'h228, "R5 MR2 literal", last_ops[4], 'h228);

    run_seq(30, 13, 20, 4, 1'b0);
    chk(last_ops[6] == 'h3024, "R4 MR0 literal CL30/WR13", last_ops[6], 'h3024);
    chk(last_ops[4] == 'h238, "R5 MR2 literal CWL20", last_ops[4], 'h238);

    run_skip();
    run_bad(29, 10, 12, 6, "R9 bad CL");
    run_bad(16, 14, 12, 6, "R9 bad WR");
    run_bad(16, 10, 13, 6, "R9 bad CWL");
    run_bad(16, 10, 12, 9, "R9 bad tCCD_L");
    run_seq(17, 11, 9, 5, 1'b1);
    run_bad(8, 4, 15, 3, "R9 all bad");
    run_seq(23, 5, 10, 6, 1'b0);

    for (int n = 0; n < 30; n++) begin
      int cl, w, cwl, ccd;
      cl  = cl_list[$urandom_range(0, 21)];
      w   = wr_list[$urandom_range(0, 8)];
      cwl = cwl_list[$urandom_range(0, 7)];
      ccd = $urandom_range(4, 8);
      if ($urandom_range(0, 5) == 0) run_bad(cl, w, cwl, 3, "R9 random bad tCCD_L");
      else run_seq(cl, w, cwl, ccd, ($urandom_range(0, 3) == 0));
    end
    finish_run();
  end

endmodule